// File: doc/BRIEF.md
# Storage Interface Register File

This block is the software-visible register set that sits in front of a storage-drive transfer engine. A host reaches it through a simple 32-bit read/write bus with word offsets. Through it the host stores the three command words, a DMA address, a DMA length and a control word. Setting the start bit of the control word sends a one-cycle start pulse to the engine, and the stored values go along with it. The engine reports back with completion, error and break events. The block turns those events into status flags, and each flag has its own enable. All enabled flags are merged into one interrupt line.

Writes to the address and length registers are masked to 32-byte alignment, and the address is also limited to a 64 MiB window. Status flags are cleared by writing a one to them. When a transfer finishes, the block drops the start bit and zeroes the length register. The engine can load a result word into the immediate buffer. A cover-open condition arrives as a single level input with its own enable. A configuration word is read-only and resets with its config bit set.

Top module: `storage_if_regs`

## Requirements
- R1: After reset, every register reads zero except the configuration word, which reads 0x0000_0001. `irq` and `xfer_start` are low after reset.
- R2: Word offsets are fixed as follows: status 0x00, cover 0x04, command words 0x08, 0x0C and 0x10, DMA address 0x14, DMA length 0x18, control 0x1C, immediate buffer 0x20, configuration 0x24. The command words and the immediate buffer store and return all 32 bits.
- R3: A write to the DMA address keeps only bits 25..5. Bits 31..26 and 4..0 read back as zero.
- R4: A write to the DMA length forces bits 4..0 to zero and keeps bits 31..5.
- R5: A control write keeps bits 2..0, and bit 0 is the start bit. A write with bit 0 set, made while the start bit is clear, gives a one-cycle `xfer_start` pulse on the same edge at which the register takes the new value. A write with bit 0 set while the start bit is already set gives no pulse.
- R6: A status write copies bit 0 (break request), bit 1 (error enable), bit 3 (completion enable) and bit 5 (break enable). A one written to bit 2, 4 or 6 clears that flag, and a zero leaves it unchanged. Bits 31..7 read zero.
- R7: When `eng_done` is high while the start bit is set, the start bit clears and the length becomes zero. The same event sets flag bit 4, or flag bit 2 if `eng_err` is high. When `eng_done` arrives with the start bit clear, nothing changes.
- R8: `eng_break` sets flag bit 6. If an engine event sets a flag in the same cycle that a write clears it, the flag stays set.
- R9: `irq` is registered. It goes high one cycle after any flag is set together with its enable. The four pairs are error (2,1), completion (4,3), break (6,5) and cover (`cover_flag`, cover bit 0).
- R10: Writes to the configuration word are ignored.
- R11: In the cover word, bit 0 is a read/write enable, bit 1 reads the `cover_flag` input, and all other bits read zero.
- R12: `imm_load` writes `imm_data` into the immediate buffer.
- R13: Read data is registered. It appears one cycle after `bus_rd`, unmapped offsets read zero, and `bus_rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |
| xfer_start | output | 1 | One-cycle transfer launch pulse |
| xfer_cmd0 | output | 32 | Command word 0 |
| xfer_cmd1 | output | 32 | Command word 1 |
| xfer_cmd2 | output | 32 | Command word 2 |
| xfer_addr | output | 32 | DMA address |
| xfer_len | output | 32 | DMA length |
| eng_done | input | 1 | Engine reports the end of a transfer |
| eng_err | input | 1 | Qualifies eng_done as an error |
| eng_break | input | 1 | Engine reports a break |
| imm_load | input | 1 | Engine loads the immediate buffer |
| imm_data | input | 32 | Value for the immediate buffer |
| cover_flag | input | 1 | Cover-open condition |

## Verification
The bench checks the masking at each edge of the legal field. A write of all ones to the address must come back as 0x03FF_FFE0, and a design that kept too many bits would return a wider value. A write of all ones to status must return only the enables and the break request. A design that stored the flag bits would show them set. The bench also covers these cases:
- A repeated start write while a transfer is running. A design without the guard would send a second launch pulse.
- A completion that arrives while the start bit is clear. A careless design would raise a flag or zero the length anyway.
- A break event in the same cycle as a clear of the same flag. A design that let the clear win would lose the interrupt.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] W_STAT  = 4'd0;
  localparam logic [IDX_W-1:0] W_COVER = 4'd1;
  localparam logic [IDX_W-1:0] W_CMD0  = 4'd2;
  localparam logic [IDX_W-1:0] W_CMD1  = 4'd3;
  localparam logic [IDX_W-1:0] W_CMD2  = 4'd4;
  localparam logic [IDX_W-1:0] W_ADDR  = 4'd5;
  localparam logic [IDX_W-1:0] W_LEN   = 4'd6;
  localparam logic [IDX_W-1:0] W_CTL   = 4'd7;
  localparam logic [IDX_W-1:0] W_IMM   = 4'd8;
  localparam logic [IDX_W-1:0] W_CFG   = 4'd9;

  // status bit positions
  localparam int B_BRKREQ = 0;
  localparam int B_ERR_EN = 1;
  localparam int B_ERR_F  = 2;
  localparam int B_TC_EN  = 3;
  localparam int B_TC_F   = 4;
  localparam int B_BRK_EN = 5;
  localparam int B_BRK_F  = 6;
  localparam int STAT_W   = 7;

  localparam int CTL_W = 3;
  localparam logic [DATA_W-1:0] ADDR_KEEP = 32'h03FF_FFE0;
  localparam logic [DATA_W-1:0] LEN_KEEP  = 32'hFFFF_FFE0;
  localparam logic [DATA_W-1:0] CFG_VALUE = 32'h0000_0001;

  // word store layout: three commands then the immediate buffer
  localparam int STORE_WORDS = 4;
  localparam int STORE_IMM   = 3;
endpackage

// File: rtl/sif_status.sv
module sif_status
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_err,
  input  logic              set_tc,
  input  logic              set_brk,
  input  logic              cov_en,
  input  logic              cov_flag,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  logic [STAT_W-1:0] clr;

  always_comb begin
    clr = '0;
    if (wr_en) begin
      clr[B_ERR_F] = wdata[B_ERR_F];
      clr[B_TC_F]  = wdata[B_TC_F];
      clr[B_BRK_F] = wdata[B_BRK_F];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en) begin
        stat_q[B_BRKREQ] <= wdata[B_BRKREQ];
        stat_q[B_ERR_EN] <= wdata[B_ERR_EN];
        stat_q[B_TC_EN]  <= wdata[B_TC_EN];
        stat_q[B_BRK_EN] <= wdata[B_BRK_EN];
      end
      // set has priority over write-one-to-clear
      stat_q[B_ERR_F] <= set_err | (stat_q[B_ERR_F] & ~clr[B_ERR_F]);
      stat_q[B_TC_F]  <= set_tc  | (stat_q[B_TC_F]  & ~clr[B_TC_F]);
      stat_q[B_BRK_F] <= set_brk | (stat_q[B_BRK_F] & ~clr[B_BRK_F]);
      irq <= (stat_q[B_ERR_F] & stat_q[B_ERR_EN]) |
             (stat_q[B_TC_F]  & stat_q[B_TC_EN])  |
             (stat_q[B_BRK_F] & stat_q[B_BRK_EN]) |
             (cov_flag & cov_en);
    end
  end
endmodule

// File: rtl/sif_dma_ctrl.sv
module sif_dma_ctrl
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_len,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output logic              finish,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] len_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              start_pulse
);
  assign finish = done & ctl_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      len_q       <= '0;
      ctl_q       <= '0;
      start_pulse <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= wdata & ADDR_KEEP;

      if (finish)      len_q <= '0;
      else if (wr_len) len_q <= wdata & LEN_KEEP;

      // completion has priority over a control write in the same cycle
      if (finish)      ctl_q[0] <= 1'b0;
      else if (wr_ctl) ctl_q    <= wdata[CTL_W-1:0];

      start_pulse <= wr_ctl & wdata[0] & ~ctl_q[0] & ~finish;
    end
  end
endmodule

// File: rtl/sif_word_store.sv
module sif_word_store #(
  parameter int WORDS    = 4,
  parameter int DW       = 32,
  parameter int LOAD_IDX = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WORDS-1:0] we,
  input  logic [DW-1:0] wdata,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] q [WORDS]
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == LOAD_IDX) begin : g_loadable
      always_ff @(posedge clk) begin
        if (rst)          q[i] <= '0;
        else if (load_en) q[i] <= load_data;
        else if (we[i])   q[i] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= '0;
        else if (we[i]) q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/storage_if_regs.sv
module storage_if_regs
  import sif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              xfer_start,
  output logic [31:0]       xfer_cmd0,
  output logic [31:0]       xfer_cmd1,
  output logic [31:0]       xfer_cmd2,
  output logic [31:0]       xfer_addr,
  output logic [31:0]       xfer_len,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_break,
  input  logic              imm_load,
  input  logic [31:0]       imm_data,
  input  logic              cover_flag
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]      sel;
  logic                  wr_stat, wr_cover, wr_addr, wr_len, wr_ctl;
  logic [STORE_WORDS-1:0] store_we;
  logic [DATA_W-1:0]     store_q [STORE_WORDS];
  logic [STAT_W-1:0]     stat_q;
  logic [DATA_W-1:0]     addr_q, len_q;
  logic [CTL_W-1:0]      ctl_q;
  logic                  finish;
  logic                  cov_en;
  logic [DATA_W-1:0]     rd_mux;

  assign sel      = bus_addr[ADDR_W-1:2];
  assign wr_stat  = bus_wr && (sel == SEL_W'(W_STAT));
  assign wr_cover = bus_wr && (sel == SEL_W'(W_COVER));
  assign wr_addr  = bus_wr && (sel == SEL_W'(W_ADDR));
  assign wr_len   = bus_wr && (sel == SEL_W'(W_LEN));
  assign wr_ctl   = bus_wr && (sel == SEL_W'(W_CTL));
  assign store_we[0] = bus_wr && (sel == SEL_W'(W_CMD0));
  assign store_we[1] = bus_wr && (sel == SEL_W'(W_CMD1));
  assign store_we[2] = bus_wr && (sel == SEL_W'(W_CMD2));
  assign store_we[STORE_IMM] = bus_wr && (sel == SEL_W'(W_IMM));

  sif_word_store #(
    .WORDS(STORE_WORDS), .DW(DATA_W), .LOAD_IDX(STORE_IMM)
  ) u_store (
    .clk(clk), .rst(rst), .we(store_we), .wdata(bus_wdata),
    .load_en(imm_load), .load_data(imm_data), .q(store_q)
  );

  sif_dma_ctrl u_dma (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_ctl(wr_ctl), .wdata(bus_wdata), .done(eng_done),
    .finish(finish), .addr_q(addr_q), .len_q(len_q), .ctl_q(ctl_q),
    .start_pulse(xfer_start)
  );

  sif_status u_stat (
    .clk(clk), .rst(rst), .wr_en(wr_stat), .wdata(bus_wdata),
    .set_err(finish & eng_err), .set_tc(finish & ~eng_err),
    .set_brk(eng_break), .cov_en(cov_en), .cov_flag(cover_flag),
    .stat_q(stat_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst)           cov_en <= 1'b0;
    else if (wr_cover) cov_en <= bus_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_W'(W_STAT):  rd_mux = DATA_W'(stat_q);
      SEL_W'(W_COVER): rd_mux = {30'd0, cover_flag, cov_en};
      SEL_W'(W_CMD0):  rd_mux = store_q[0];
      SEL_W'(W_CMD1):  rd_mux = store_q[1];
      SEL_W'(W_CMD2):  rd_mux = store_q[2];
      SEL_W'(W_ADDR):  rd_mux = addr_q;
      SEL_W'(W_LEN):   rd_mux = len_q;
      SEL_W'(W_CTL):   rd_mux = DATA_W'(ctl_q);
      SEL_W'(W_IMM):   rd_mux = store_q[STORE_IMM];
      SEL_W'(W_CFG):   rd_mux = CFG_VALUE;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign xfer_cmd0 = store_q[0];
  assign xfer_cmd1 = store_q[1];
  assign xfer_cmd2 = store_q[2];
  assign xfer_addr = addr_q;
  assign xfer_len  = len_q;
endmodule

// File: rtl/sif_checker.sv
module sif_checker
  import sif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              xfer_start,
  input logic [31:0]       xfer_addr,
  input logic [31:0]       xfer_len,
  input logic              eng_done,
  input logic              eng_break,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              cov_en,
  input logic              irq
);
  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  assert_start_from_write_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_CTL) && bus_wdata[0]));

  assert_addr_align_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_addr[4:0] == 5'd0 && xfer_addr[31:26] == 6'd0);

  assert_len_align_R4: assert property (@(posedge clk) disable iff (rst)
    xfer_len[4:0] == 5'd0);

  assert_finish_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_done && ctl_q[0]) |=> (xfer_len == 32'd0 && !ctl_q[0]));

  assert_break_sets_R8: assert property (@(posedge clk) disable iff (rst)
    eng_break |=> stat_q[B_BRK_F]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[B_ERR_EN] && !stat_q[B_TC_EN] && !stat_q[B_BRK_EN] && !cov_en) |=> !irq);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind storage_if_regs sif_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .eng_done(eng_done), .eng_break(eng_break), .ctl_q(ctl_q),
  .stat_q(stat_q), .cov_en(cov_en), .irq(irq)
);

// File: tb/sim_storage_if_regs.sv
module sim_storage_if_regs;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, xfer_start;
  logic [31:0] xfer_cmd0, xfer_cmd1, xfer_cmd2, xfer_addr, xfer_len;
  logic eng_done = 0, eng_err = 0, eng_break = 0, imm_load = 0, cover_flag = 0;
  logic [31:0] imm_data = '0;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  storage_if_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .xfer_start(xfer_start), .xfer_cmd0(xfer_cmd0),
    .xfer_cmd1(xfer_cmd1), .xfer_cmd2(xfer_cmd2), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .eng_done(eng_done), .eng_err(eng_err),
    .eng_break(eng_break), .imm_load(imm_load), .imm_data(imm_data),
    .cover_flag(cover_flag)
  );

  // {offset, write value, expected readback}
  localparam logic [95:0] VEC [10] = '{
    {32'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2 cmd0
    {32'h0C, 32'h1234_5678, 32'h1234_5678},  // R2 cmd1
    {32'h10, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R2 cmd2
    {32'h20, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R2 imm
    {32'h14, 32'hFFFF_FFFF, 32'h03FF_FFE0},  // R3 address mask
    {32'h18, 32'hFFFF_FFFF, 32'hFFFF_FFE0},  // R4 length mask
    {32'h1C, 32'hFFFF_FFFA, 32'h0000_0002},  // R5 control low bits, no start
    {32'h00, 32'hFFFF_FFFF, 32'h0000_002B},  // R6 status enables only
    {32'h24, 32'h0000_0000, 32'h0000_0001},  // R10 config ignores writes
    {32'h04, 32'hFFFF_FFFF, 32'h0000_0001}   // R11 cover enable only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a[AW-1:0];
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 start", {31'd0, xfer_start}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      rd(i * 4, v);
      check("R1 reset read", v, (i == 9) ? 32'h1 : 32'h0);
    end
    // R13 unmapped offset
    rd(32'h3C, v);
    check("R13 unmapped", v, 32'h0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][95:64], VEC[i][63:32]);
      rd(VEC[i][95:64], v);
      check("R2-table", v, VEC[i][31:0]);
    end
    // R13 hold while idle
    @(negedge clk); @(negedge clk);
    check("R13 hold", bus_rdata, 32'h1);

    // clear enables
    wr(32'h00, 32'h0000_0000);
    wr(32'h04, 32'h0);
    wr(32'h1C, 32'h0);

    // R5 start pulse
    wr(32'h18, 32'h0000_0400);
    wr(32'h1C, 32'h0000_0001);
    check("R5 pulse", {31'd0, xfer_start}, 32'd1);
    check("R5 cmd0 out", xfer_cmd0, 32'hDEAD_BEEF);
    check("R5 addr out", xfer_addr, 32'h03FF_FFE0);
    check("R5 len out", xfer_len, 32'h0000_0400);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, xfer_start}, 32'd0);
    wr(32'h1C, 32'h0000_0001);
    check("R5 no second pulse", {31'd0, xfer_start}, 32'd0);

    // R7 completion
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(32'h1C, v); check("R7 start cleared", v, 32'h0);
    rd(32'h18, v); check("R7 length zero", v, 32'h0);
    rd(32'h00, v); check("R7 tc flag", v, 32'h0000_0010);

    // R9 irq with tc enable
    wr(32'h00, 32'h0000_0008);
    @(negedge clk);
    check("R9 irq tc", {31'd0, irq}, 32'd1);
    // R6 write-one-to-clear
    wr(32'h00, 32'h0000_0018);
    rd(32'h00, v); check("R6 w1c", v, 32'h0000_0008);
    @(negedge clk);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // R7 completion without start is ignored
    wr(32'h18, 32'h0000_0100);
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(32'h00, v); check("R7 idle done status", v, 32'h0000_0008);
    rd(32'h18, v); check("R7 idle done length", v, 32'h0000_0100);

    // R7 error completion
    wr(32'h1C, 32'h0000_0001);
    @(negedge clk); eng_done = 1; eng_err = 1;
    @(negedge clk); eng_done = 0; eng_err = 0;
    rd(32'h00, v); check("R7 err flag", v, 32'h0000_000C);
    wr(32'h00, 32'h0000_0004);
    rd(32'h00, v); check("R6 err cleared", v, 32'h0);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    eng_break = 1; bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'h0000_0040;
    @(negedge clk);
    eng_break = 0; bus_wr = 0;
    rd(32'h00, v); check("R8 break kept", v, 32'h0000_0040);
    wr(32'h00, 32'h0000_0020);
    @(negedge clk);
    check("R9 irq break", {31'd0, irq}, 32'd1);
    wr(32'h00, 32'h0000_0040);
    @(negedge clk);
    check("R9 irq break cleared", {31'd0, irq}, 32'd0);

    // R11 / R9 cover pair
    cover_flag = 1;
    rd(32'h04, v); check("R11 cover flag", v, 32'h0000_0002);
    @(negedge clk);
    check("R9 cover masked", {31'd0, irq}, 32'd0);
    wr(32'h04, 32'h1);
    @(negedge clk);
    check("R9 cover irq", {31'd0, irq}, 32'd1);
    cover_flag = 0;

    // R12 engine load of immediate buffer
    @(negedge clk); imm_load = 1; imm_data = 32'h0BAD_CAFE;
    @(negedge clk); imm_load = 0;
    rd(32'h20, v); check("R12 imm load", v, 32'h0BAD_CAFE);

    // R1 reset again mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(32'h08, v); check("R1 cmd after reset", v, 32'h0);
    rd(32'h24, v); check("R1 cfg after reset", v, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule